// File: doc/BRIEF.md
# Low-Power Mode Controller

The controller sequences a small processor system through three power-saving depths. A control write from the CPU selects deep sleep, clock hold or CPU idle. Each depth drives its own set of outputs: a CPU clock enable, a system clock enable, an oscillator-stop request and a memory chip-select disable. The controller runs on an always-on clock and watches wake events from an external port, a watchdog and a real-time counter, plus a vector of peripheral interrupt lines. All of these inputs are asynchronous, and each passes through a two-flop synchronizer.

When a wake is taken, the controller leaves the low-power depth. It pulses a wake indication and reports two things: the winning source, and the action the CPU must take. That action is to resume at the next instruction, vector to the source's interrupt routine, or accept a reset. Sleep wakes always end in a reset request, which is held for a fixed number of cycles. Hold wakes follow the interrupt and watchdog-reset enables. Idle wakes always vector to an interrupt routine.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the controller is in the run state: mode_o = 0, both clock enables high, osc_stop_o, mem_cs_dis_o, rst_req_o and wake_o low.
- R2: In the run state a write with ctrl_we_i high takes effect at the next edge. ctrl_wdata_i bit 0 selects sleep (mode_o = 1), bit 1 selects hold (mode_o = 2) and bit 2 selects idle (mode_o = 3). Sleep beats hold, and hold beats idle. A write of zero, or any write made outside the run state, is ignored.
- R3: In sleep both clock enables are low, and osc_stop_o and mem_cs_dis_o are high.
- R4: Sleep is left only by a port, watchdog or real-time counter event, always with action reset (wake_act_o = 2). Peripheral interrupts are ignored in sleep.
- R5: A reset action holds rst_req_o high for exactly RST_CYC cycles (default 4). During that time mode_o = 0 and both clock enables are high. The controller then returns to run.
- R6: In hold both clock enables are low while osc_stop_o and mem_cs_dis_o stay low. Peripheral interrupts do not end hold.
- R7: A port or real-time counter wake from hold gives action ISR (1) if that source's interrupt enable is set, else action resume (0).
- R8: A watchdog wake from hold gives reset (2) if wdt_rst_en_i is set. Otherwise it gives ISR if wdt_ie_i is set, and resume if neither is set.
- R9: When several events are present together, the reported source is the watchdog (wake_src_o = 2) first, then the real-time counter (1), then the port (0), then a peripheral interrupt (3).
- R10: In idle only the CPU clock enable is low. Any event, including any peripheral interrupt, ends idle with action ISR.
- R11: An event first driven between two clock edges produces a one-cycle wake_o pulse after the third following edge. The same edge returns mode_o to 0 (or 0 with rst_req_o for a reset action).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 3 | Mode request bits: 0 sleep, 1 hold, 2 idle |
| port_wake_i | input | 1 | External port wake event (async) |
| wdt_evt_i | input | 1 | Watchdog event (async) |
| rtc_evt_i | input | 1 | Real-time counter event (async) |
| periph_irq_i | input | NUM_IRQ | Peripheral interrupt lines (async) |
| port_ie_i | input | 1 | Port interrupt enable |
| rtc_ie_i | input | 1 | Real-time counter interrupt enable |
| wdt_ie_i | input | 1 | Watchdog interrupt enable |
| wdt_rst_en_i | input | 1 | Watchdog reset enable |
| cpu_clk_en_o | output | 1 | CPU clock domain enable |
| sys_clk_en_o | output | 1 | System clock domain enable |
| osc_stop_o | output | 1 | Request to stop all clock sources |
| mem_cs_dis_o | output | 1 | Force memory chip selects inactive |
| rst_req_o | output | 1 | System reset request |
| wake_o | output | 1 | One-cycle pulse on leaving a low-power depth |
| wake_act_o | output | 2 | Action for the CPU: 0 resume, 1 ISR, 2 reset |
| wake_src_o | output | 2 | Source: 0 port, 1 rtc, 2 watchdog, 3 peripheral |
| mode_o | output | 2 | Current mode: 0 run, 1 sleep, 2 hold, 3 idle |

## Verification
Each depth is woken by every source on its own, and by several sources together. One property of the wake then separates the three depths: a reset action always follows a sleep wake, the enables decide the action in hold, and an ISR always follows an idle wake. In hold the watchdog is run through all three combinations of reset enable and interrupt enable, which exposes the priority between them. The port and the real-time counter are run with their enables set and clear. Peripheral interrupts are applied in sleep and hold, where they must have no effect, and in idle, where they must wake. Every wake is timed against the synchronizer latency, and every reset pulse is measured.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  localparam int unsigned CTRL_W     = 3;
  localparam int unsigned CTRL_SLEEP = 0;
  localparam int unsigned CTRL_HOLD  = 1;
  localparam int unsigned CTRL_IDLE  = 2;

  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_SLEEP = 3'd1,
    ST_HOLD  = 3'd2,
    ST_IDLE  = 3'd3,
    ST_RSTQ  = 3'd4
  } pwr_state_e;

  typedef enum logic [1:0] {
    ACT_RESUME = 2'd0,
    ACT_ISR    = 2'd1,
    ACT_RESET  = 2'd2
  } wake_act_e;

  typedef enum logic [1:0] {
    SRC_PORT   = 2'd0,
    SRC_RTC    = 2'd1,
    SRC_WDT    = 2'd2,
    SRC_PERIPH = 2'd3
  } wake_src_e;

  localparam logic [1:0] MODE_RUN   = 2'd0;
  localparam logic [1:0] MODE_SLEEP = 2'd1;
  localparam logic [1:0] MODE_HOLD  = 2'd2;
  localparam logic [1:0] MODE_IDLE  = 2'd3;
endpackage

// File: rtl/pwr_wake_sync.sv
module pwr_wake_sync #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= async_i[i];
        s2_q <= s1_q;
      end
    end
    assign sync_o[i] = s2_q;

    // an event quiet for two edges cannot appear at the output
    AST_SYNC_NO_EARLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!$past(async_i[i]) && !$past(async_i[i], 2)) |-> !sync_o[i]); // R11
  end
endmodule

// File: rtl/pwr_wake_arb.sv
module pwr_wake_arb
  import pwr_pkg::*;
(
  input  pwr_state_e state_i,
  input  logic       ev_port_i,
  input  logic       ev_wdt_i,
  input  logic       ev_rtc_i,
  input  logic       ev_irq_i,
  input  logic       port_ie_i,
  input  logic       rtc_ie_i,
  input  logic       wdt_ie_i,
  input  logic       wdt_rst_en_i,
  output logic       hit_o,
  output wake_act_e  act_o,
  output wake_src_e  src_o
);
  logic ext_hit;
  wake_act_e hold_act;

  assign ext_hit = ev_port_i | ev_wdt_i | ev_rtc_i;

  // fixed priority: watchdog, rtc, port, peripheral
  always_comb begin
    if (ev_wdt_i)       src_o = SRC_WDT;
    else if (ev_rtc_i)  src_o = SRC_RTC;
    else if (ev_port_i) src_o = SRC_PORT;
    else                src_o = SRC_PERIPH;
  end

  always_comb begin
    unique case (src_o)
      SRC_WDT:  hold_act = wdt_rst_en_i ? ACT_RESET :
                           (wdt_ie_i ? ACT_ISR : ACT_RESUME);
      SRC_RTC:  hold_act = rtc_ie_i  ? ACT_ISR : ACT_RESUME;
      SRC_PORT: hold_act = port_ie_i ? ACT_ISR : ACT_RESUME;
      default:  hold_act = ACT_RESUME;
    endcase
  end

  always_comb begin
    hit_o = 1'b0;
    act_o = ACT_RESUME;
    unique case (state_i)
      ST_SLEEP: begin
        hit_o = ext_hit;
        act_o = ACT_RESET;
      end
      ST_HOLD: begin
        hit_o = ext_hit;
        act_o = hold_act;
      end
      ST_IDLE: begin
        hit_o = ext_hit | ev_irq_i;
        act_o = ACT_ISR;
      end
      default: begin
        hit_o = 1'b0;
        act_o = ACT_RESUME;
      end
    endcase
  end
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_pkg::*;
#(
  parameter int unsigned RST_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic              hit_i,
  input  wake_act_e         act_i,
  input  wake_src_e         src_i,
  output pwr_state_e        state_o,
  output logic              wake_o,
  output wake_act_e         wake_act_o,
  output wake_src_e         wake_src_o
);
  localparam int unsigned CNT_W = (RST_CYC > 1) ? $clog2(RST_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RST_CYC - 1);

  pwr_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic lp_state;

  assign lp_state = (state_q == ST_SLEEP) || (state_q == ST_HOLD) || (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_RUN: begin
        if (ctrl_we_i) begin
          if (ctrl_wdata_i[CTRL_SLEEP])     state_d = ST_SLEEP;
          else if (ctrl_wdata_i[CTRL_HOLD]) state_d = ST_HOLD;
          else if (ctrl_wdata_i[CTRL_IDLE]) state_d = ST_IDLE;
        end
      end
      ST_SLEEP, ST_HOLD, ST_IDLE: begin
        if (hit_i) begin
          if (act_i == ACT_RESET) begin
            state_d = ST_RSTQ;
            cnt_d   = CNT_LOAD;
          end else begin
            state_d = ST_RUN;
          end
        end
      end
      ST_RSTQ: begin
        if (cnt_q == '0) state_d = ST_RUN;
        else             cnt_d   = cnt_q - 1'b1;
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_RUN;
      cnt_q      <= '0;
      wake_o     <= 1'b0;
      wake_act_o <= ACT_RESUME;
      wake_src_o <= SRC_PORT;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      wake_o  <= lp_state && hit_i;
      if (lp_state && hit_i) begin
        wake_act_o <= act_i;
        wake_src_o <= src_i;
      end
    end
  end

  assign state_o = state_q;

  AST_SLEEP_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && ctrl_we_i && ctrl_wdata_i[CTRL_SLEEP]) |=> state_q == ST_SLEEP); // R2
  AST_HOLD_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HOLD && !hit_i) |=> state_q == ST_HOLD); // R6
  AST_WAKE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o); // R11
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 4,
  parameter int unsigned RST_CYC = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ctrl_we_i,
  input  logic [2:0]         ctrl_wdata_i,
  input  logic               port_wake_i,
  input  logic               wdt_evt_i,
  input  logic               rtc_evt_i,
  input  logic [NUM_IRQ-1:0] periph_irq_i,
  input  logic               port_ie_i,
  input  logic               rtc_ie_i,
  input  logic               wdt_ie_i,
  input  logic               wdt_rst_en_i,
  output logic               cpu_clk_en_o,
  output logic               sys_clk_en_o,
  output logic               osc_stop_o,
  output logic               mem_cs_dis_o,
  output logic               rst_req_o,
  output logic               wake_o,
  output logic [1:0]         wake_act_o,
  output logic [1:0]         wake_src_o,
  output logic [1:0]         mode_o
);
  localparam int unsigned SYNC_W = 3 + NUM_IRQ;
  localparam int unsigned LEN_W  = $clog2(RST_CYC + 2) + 1;

  logic [SYNC_W-1:0] ev_sync;
  logic       ev_irq_any;
  logic       hit;
  wake_act_e  act, act_q;
  wake_src_e  src, src_q;
  pwr_state_e state;

  pwr_wake_sync #(.WIDTH(SYNC_W)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({periph_irq_i, rtc_evt_i, wdt_evt_i, port_wake_i}),
    .sync_o  (ev_sync)
  );

  assign ev_irq_any = |ev_sync[SYNC_W-1:3];

  pwr_wake_arb u_arb (
    .state_i      (state),
    .ev_port_i    (ev_sync[0]),
    .ev_wdt_i     (ev_sync[1]),
    .ev_rtc_i     (ev_sync[2]),
    .ev_irq_i     (ev_irq_any),
    .port_ie_i    (port_ie_i),
    .rtc_ie_i     (rtc_ie_i),
    .wdt_ie_i     (wdt_ie_i),
    .wdt_rst_en_i (wdt_rst_en_i),
    .hit_o        (hit),
    .act_o        (act),
    .src_o        (src)
  );

  pwr_mode_fsm #(.RST_CYC(RST_CYC)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ctrl_we_i    (ctrl_we_i),
    .ctrl_wdata_i (ctrl_wdata_i),
    .hit_i        (hit),
    .act_i        (act),
    .src_i        (src),
    .state_o      (state),
    .wake_o       (wake_o),
    .wake_act_o   (act_q),
    .wake_src_o   (src_q)
  );

  assign wake_act_o = act_q;
  assign wake_src_o = src_q;

  // enables decoded straight from the state flops: they move only on a clock edge
  always_comb begin
    cpu_clk_en_o = 1'b0;
    sys_clk_en_o = 1'b0;
    osc_stop_o   = 1'b0;
    mem_cs_dis_o = 1'b0;
    rst_req_o    = 1'b0;
    mode_o       = MODE_RUN;
    unique case (state)
      ST_SLEEP: begin
        osc_stop_o   = 1'b1;
        mem_cs_dis_o = 1'b1;
        mode_o       = MODE_SLEEP;
      end
      ST_HOLD: mode_o = MODE_HOLD;
      ST_IDLE: begin
        sys_clk_en_o = 1'b1;
        mode_o       = MODE_IDLE;
      end
      ST_RSTQ: begin
        cpu_clk_en_o = 1'b1;
        sys_clk_en_o = 1'b1;
        rst_req_o    = 1'b1;
      end
      default: begin
        cpu_clk_en_o = 1'b1;
        sys_clk_en_o = 1'b1;
      end
    endcase
  end

  // reset pulse length tracker for the checks below
  logic [LEN_W-1:0] rst_len_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     rst_len_q <= '0;
    else if (!rst_req_o)             rst_len_q <= '0;
    else if (rst_len_q != '1)        rst_len_q <= rst_len_q + 1'b1;
  end

  AST_SLEEP_WAKE_RESETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_SLEEP && hit) |=> rst_req_o); // R4
  AST_RST_MIN_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_req_o) |-> rst_len_q >= LEN_W'(RST_CYC)); // R5
  AST_RST_MAX_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> rst_len_q < LEN_W'(RST_CYC)); // R5
  AST_WDT_RESET_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_HOLD && ev_sync[1] && wdt_rst_en_i) |=> rst_req_o); // R8
  AST_IDLE_ANY_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_IDLE && ev_irq_any) |=> (wake_o && mode_o == MODE_RUN)); // R10
endmodule

// File: tb/pwr_mode_ctrl_test.sv
module pwr_mode_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_IRQ    = 4;
  localparam int RST_CYC    = 4;
  localparam int A_RESUME = 0, A_ISR = 1, A_RESET = 2;
  localparam int S_PORT = 0, S_RTC = 1, S_WDT = 2, S_PERIPH = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0;
  logic [2:0] wd = '0;
  logic port = 1'b0, wdt = 1'b0, rtc = 1'b0;
  logic [NUM_IRQ-1:0] irq = '0;
  logic port_ie = 1'b0, rtc_ie = 1'b0, wdt_ie = 1'b0, wdt_rst_en = 1'b0;
  logic cpu_en, sys_en, osc_stop, mem_dis, rst_req, wake;
  logic [1:0] wake_act, wake_src, mode;

  pwr_mode_ctrl #(.NUM_IRQ(NUM_IRQ), .RST_CYC(RST_CYC)) uut (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_we_i(we), .ctrl_wdata_i(wd),
    .port_wake_i(port), .wdt_evt_i(wdt), .rtc_evt_i(rtc), .periph_irq_i(irq),
    .port_ie_i(port_ie), .rtc_ie_i(rtc_ie), .wdt_ie_i(wdt_ie), .wdt_rst_en_i(wdt_rst_en),
    .cpu_clk_en_o(cpu_en), .sys_clk_en_o(sys_en), .osc_stop_o(osc_stop),
    .mem_cs_dis_o(mem_dis), .rst_req_o(rst_req), .wake_o(wake),
    .wake_act_o(wake_act), .wake_src_o(wake_src), .mode_o(mode)
  );

  typedef struct {
    int     act;
    int     src;
    longint cyc;
    string  tag;
  } exp_t;

  exp_t   exp_q[$];
  int     n_cmp = 0;
  int     n_bad = 0;
  longint cyc = 0;
  int     rst_run = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // monitor: pops one expected wake per wake_o pulse, measures reset pulses
  always @(negedge clk) begin
    if (rst_n) begin
      if (wake) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R11", "unexpected wake pulse", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(wake_act == e.act, e.tag, "wake action", wake_act, e.act);
          check(wake_src == e.src, e.tag, "wake source", wake_src, e.src);
          check(cyc == e.cyc, "R11", "wake cycle", cyc, e.cyc);
        end
      end
      if (rst_req) rst_run++;
      else if (rst_run > 0) begin
        check(rst_run == RST_CYC, "R5", "reset pulse length", rst_run, RST_CYC);
        rst_run = 0;
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] v);
    @(negedge clk);
    we = 1'b1;
    wd = v;
    @(negedge clk);
    we = 1'b0;
    wd = '0;
  endtask

  task automatic chk_mode(input int exp, input string tag);
    check(mode == 2'(exp), tag, "mode", mode, exp);
  endtask

  task automatic chk_outs(input bit c, input bit s, input bit o, input bit m, input string tag);
    check(cpu_en == c,   tag, "cpu_clk_en", cpu_en, c);
    check(sys_en == s,   tag, "sys_clk_en", sys_en, s);
    check(osc_stop == o, tag, "osc_stop", osc_stop, o);
    check(mem_dis == m,  tag, "mem_cs_dis", mem_dis, m);
  endtask

  // driver: raise events, record the expected wake, then release
  task automatic hit(input bit p, input bit w, input bit r, input logic [NUM_IRQ-1:0] iq,
                     input int act, input int src, input string tag);
    exp_t e;
    port = p; wdt = w; rtc = r; irq = iq;
    e.act = act; e.src = src; e.cyc = cyc + 3; e.tag = tag;
    exp_q.push_back(e);
    tick(5);
    port = 1'b0; wdt = 1'b0; rtc = 1'b0; irq = '0;
    tick(RST_CYC + 4);
    chk_mode(0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    check(1'b0, "WATCHDOG", "run did not finish", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    chk_mode(0, "R1");
    chk_outs(1, 1, 0, 0, "R1");
    check(!rst_req && !wake, "R1", "rst_req/wake", {rst_req, wake}, 0);

    // R2 zero write ignored, sleep precedence
    wr(3'b000);
    chk_mode(0, "R2");
    wr(3'b111);
    chk_mode(1, "R2");
    chk_outs(0, 0, 1, 1, "R3");

    // R4 peripheral irq ignored in sleep
    irq = 4'b1001;
    tick(6);
    irq = '0;
    chk_mode(1, "R4");
    tick(3);
    hit(1, 0, 0, '0, A_RESET, S_PORT, "R4");
    chk_outs(1, 1, 0, 0, "R5");

    wr(3'b001);
    hit(0, 1, 1, '0, A_RESET, S_WDT, "R4");
    wr(3'b001);
    hit(0, 0, 1, '0, A_RESET, S_RTC, "R4");

    // R2 hold beats idle; R6 outputs
    wr(3'b110);
    chk_mode(2, "R2");
    chk_outs(0, 0, 0, 0, "R6");
    wr(3'b100);
    chk_mode(2, "R2");
    irq = 4'b0100;
    tick(6);
    irq = '0;
    chk_mode(2, "R6");
    tick(3);

    // R7 port/rtc from hold
    hit(1, 0, 0, '0, A_RESUME, S_PORT, "R7");
    port_ie = 1'b1;
    wr(3'b010);
    hit(1, 0, 0, '0, A_ISR, S_PORT, "R7");
    rtc_ie = 1'b1;
    wr(3'b010);
    hit(0, 0, 1, '0, A_ISR, S_RTC, "R7");
    rtc_ie = 1'b0;
    wr(3'b010);
    hit(0, 0, 1, '0, A_RESUME, S_RTC, "R7");

    // R8 watchdog from hold
    wdt_rst_en = 1'b1; wdt_ie = 1'b1;
    wr(3'b010);
    hit(0, 1, 0, '0, A_RESET, S_WDT, "R8");
    wdt_rst_en = 1'b0;
    wr(3'b010);
    hit(0, 1, 0, '0, A_ISR, S_WDT, "R8");
    wdt_ie = 1'b0;
    wr(3'b010);
    hit(0, 1, 0, '0, A_RESUME, S_WDT, "R8");

    // R9 simultaneous events
    rtc_ie = 1'b1;
    wr(3'b010);
    hit(1, 0, 1, '0, A_ISR, S_RTC, "R9");
    wr(3'b010);
    hit(1, 1, 1, '0, A_RESUME, S_WDT, "R9");

    // R10 idle
    port_ie = 1'b0;
    wr(3'b100);
    chk_mode(3, "R10");
    chk_outs(0, 1, 0, 0, "R10");
    hit(0, 0, 0, 4'b0100, A_ISR, S_PERIPH, "R10");
    wr(3'b100);
    hit(1, 0, 0, 4'b0001, A_ISR, S_PORT, "R10");

    tick(4);
    check(exp_q.size() == 0, "R11", "missing wake pulses", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule